// File: doc/BRIEF.md
# Word-Serial AES-128 Encryption Datapath

This block encrypts one 128-bit block under AES-128. It works on one 32-bit column per clock, with four byte substitution units and one column mixer. The plaintext and the cipher key enter together as four 32-bit word pairs. Each pair is combined by XOR as it arrives, so the initial key addition costs no extra cycle.

After the fourth pair is taken, the block runs ten rounds of four cycles each. In every round cycle it asks an external key-expansion block for one round-key word through `rk_idx` and reads that word on `rk_word` in the same cycle. The partial results of a round collect in an accumulator register. When the last column of a round is done, the whole new state is written back into the state register. The accumulator also drives the ciphertext output.

Bytes are mapped column-major: word k holds column k, and within a word bits [31:24] are row 0 and bits [7:0] are row 3. The first word loaded is byte 0 to byte 3 of the block.

Top module: `aes_ws_core`

## Requirements
- R1: A load word pair is taken on each rising edge where `ld_vld` is high while `busy` is low. The word stored is `ld_data ^ ld_key`, placed into columns 0, 1, 2 and 3 in arrival order. `busy` stays low after three words and rises on the edge that takes the fourth.
- R2: While `busy` is high, `ld_vld`, `ld_data` and `ld_key` have no effect on the result of the encryption in progress.
- R3: `ct` equals the AES-128 encryption of the loaded plaintext under the loaded key. Every round uses the S-box, the row rotation (row n moves left by n bytes) and the key addition. Column mixing multiplies by the constants 1, 2 and 3, and doubling reduces by 0x1B when the top bit is set. Column mixing is used in rounds 1 to 9 and left out in round 10.
- R4: On each busy cycle, `rk_idx` equals 4*round + column, with round running 1 to 10 and column 0 to 3. It starts at 4 and rises by one per cycle up to 43.
- R5: `done` is a one-cycle pulse. It is seen exactly 40 cycles after the edge that took the fourth load word, on the same edge where `busy` falls.
- R6: `ct` changes only on edges where the block is busy or where `done` rises. After `done`, it holds the ciphertext until the next encryption starts.
- R7: Idle cycles between load words (`ld_vld` low) are allowed. The word count advances only on cycles where a word is taken.
- R8: After reset, `busy`, `done`, `ct` and `rk_idx` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_vld | input | 1 | A plaintext/key word pair is present |
| ld_data | input | 32 | Plaintext column word |
| ld_key | input | 32 | Cipher key column word |
| rk_word | input | 32 | Round-key word selected by `rk_idx` |
| rk_idx | output | 6 | Index of the round-key word needed this cycle |
| busy | output | 1 | Rounds are in progress |
| done | output | 1 | One-cycle pulse: `ct` is valid |
| ct | output | 128 | Ciphertext (accumulator register) |

## Verification
A wrong byte in the state register spreads through the column mixer to a whole column in the next round and to the whole block one round later. Any such fault therefore shows in `ct` at the `done` pulse, at most 40 cycles later. A wrong round or column counter shows at once, in the cycle it happens, as a break in the `rk_idx` sequence or as a `done` pulse that is early or late. The bench checks the index sequence on every busy cycle and the exact `done` cycle as well as the ciphertext.

// File: rtl/aes_ws_pkg.sv
package aes_ws_pkg;
    localparam int BYTE_W  = 8;
    localparam int NROW    = 4;
    localparam int NCOL    = 4;
    localparam int WORD_W  = BYTE_W * NROW;
    localparam int BLOCK_W = WORD_W * NCOL;

    typedef enum logic { PH_IDLE, PH_RUN } phase_e;

    // Multiply by x in GF(2^8), polynomial x^8+x^4+x^3+x+1
    function automatic logic [7:0] gf_dbl(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    // General GF(2^8) product, shift-and-add
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] p;
        acc = 8'h00;
        p   = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ p;
            p = gf_dbl(p);
        end
        return acc;
    endfunction
endpackage

// File: rtl/aes_ws_sbox.sv
module aes_ws_sbox
    import aes_ws_pkg::*;
(
    input  logic [BYTE_W-1:0] a_i,
    output logic [BYTE_W-1:0] y_o
);
    logic [7:0] sq_d, inv_d;

    // Inverse as a^254 = product of a^(2^k), k = 1..7; zero maps to zero
    always_comb begin
        sq_d  = a_i;
        inv_d = 8'h01;
        for (int k = 1; k < 8; k++) begin
            sq_d  = gf_mul(sq_d, sq_d);
            inv_d = gf_mul(inv_d, sq_d);
        end
        y_o = inv_d
            ^ {inv_d[6:0], inv_d[7]}
            ^ {inv_d[5:0], inv_d[7:6]}
            ^ {inv_d[4:0], inv_d[7:5]}
            ^ {inv_d[3:0], inv_d[7:4]}
            ^ 8'h63;
    end
endmodule

// File: rtl/aes_ws_mixcol.sv
module aes_ws_mixcol
    import aes_ws_pkg::*;
(
    input  logic [WORD_W-1:0] col_i,
    input  logic              bypass_i,
    output logic [WORD_W-1:0] col_o
);
    logic [7:0] b_d [NROW];
    logic [7:0] d_d [NROW];
    logic [7:0] m_d [NROW];

    always_comb begin
        for (int r = 0; r < NROW; r++) begin
            b_d[r] = col_i[WORD_W-1-BYTE_W*r -: BYTE_W];
            d_d[r] = gf_dbl(b_d[r]);
        end
        // out[r] = 2*b[r] ^ 3*b[r+1] ^ b[r+2] ^ b[r+3]
        for (int r = 0; r < NROW; r++) begin
            m_d[r] = d_d[r]
                   ^ d_d[(r+1)%NROW] ^ b_d[(r+1)%NROW]
                   ^ b_d[(r+2)%NROW]
                   ^ b_d[(r+3)%NROW];
        end
        col_o = bypass_i ? col_i : {m_d[0], m_d[1], m_d[2], m_d[3]};
    end
endmodule

// File: rtl/aes_ws_core.sv
module aes_ws_core
    import aes_ws_pkg::*;
#(
    parameter  int NUM_ROUNDS = 10,
    localparam int RND_W      = $clog2(NUM_ROUNDS + 1),
    localparam int COL_W      = $clog2(NCOL),
    localparam int IDX_W      = RND_W + COL_W
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_vld,
    input  logic [WORD_W-1:0]  ld_data,
    input  logic [WORD_W-1:0]  ld_key,
    input  logic [WORD_W-1:0]  rk_word,
    output logic [IDX_W-1:0]   rk_idx,
    output logic               busy,
    output logic               done,
    output logic [BLOCK_W-1:0] ct
);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(NCOL - 1);
    localparam logic [RND_W-1:0] LAST_RND = RND_W'(NUM_ROUNDS);

    typedef struct packed {
        phase_e             phase;
        logic [RND_W-1:0]   round;
        logic [COL_W-1:0]   col;
        logic [BLOCK_W-1:0] state;
        logic [BLOCK_W-1:0] acc;
        logic               done;
    } regs_t;

    regs_t r_q, r_d;

    logic [WORD_W-1:0] st_col_d [NCOL];
    logic [COL_W-1:0]  sel_d    [NROW];
    logic [BYTE_W-1:0] sb_in_d  [NROW];
    logic [BYTE_W-1:0] sb_out_d [NROW];
    logic [WORD_W-1:0] sub_col_d, mix_col_d, new_col_d;

    // Row rotation: row r of output column c comes from state column c+r
    always_comb begin
        for (int k = 0; k < NCOL; k++)
            st_col_d[k] = r_q.state[BLOCK_W-1-WORD_W*k -: WORD_W];
        for (int r = 0; r < NROW; r++) begin
            sel_d[r]   = r_q.col + COL_W'(r);
            sb_in_d[r] = st_col_d[sel_d[r]][WORD_W-1-BYTE_W*r -: BYTE_W];
        end
    end

    for (genvar g = 0; g < NROW; g++) begin : g_sbox
        aes_ws_sbox i_sbox (.a_i(sb_in_d[g]), .y_o(sb_out_d[g]));
        assign sub_col_d[WORD_W-1-BYTE_W*g -: BYTE_W] = sb_out_d[g];
    end

    aes_ws_mixcol i_mix (
        .col_i    (sub_col_d),
        .bypass_i (r_q.round == LAST_RND),
        .col_o    (mix_col_d)
    );

    assign new_col_d = mix_col_d ^ rk_word;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.phase)
            PH_IDLE: begin
                if (ld_vld) begin
                    for (int k = 0; k < NCOL; k++)
                        if (COL_W'(k) == r_q.col)
                            r_d.state[BLOCK_W-1-WORD_W*k -: WORD_W] = ld_data ^ ld_key;
                    r_d.col = r_q.col + 1'b1;
                    if (r_q.col == LAST_COL) begin
                        r_d.phase = PH_RUN;
                        r_d.round = RND_W'(1);
                    end
                end
            end
            PH_RUN: begin
                for (int k = 0; k < NCOL; k++)
                    if (COL_W'(k) == r_q.col)
                        r_d.acc[BLOCK_W-1-WORD_W*k -: WORD_W] = new_col_d;
                r_d.col = r_q.col + 1'b1;
                if (r_q.col == LAST_COL) begin
                    r_d.state = {r_q.acc[BLOCK_W-1:WORD_W], new_col_d};
                    if (r_q.round == LAST_RND) begin
                        r_d.phase = PH_IDLE;
                        r_d.round = '0;
                        r_d.done  = 1'b1;
                    end else begin
                        r_d.round = r_q.round + 1'b1;
                    end
                end
            end
            default: r_d = r_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{phase: PH_IDLE, round: '0, col: '0, state: '0, acc: '0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign rk_idx = {r_q.round, r_q.col};
    assign busy   = (r_q.phase == PH_RUN);
    assign done   = r_q.done;
    assign ct     = r_q.acc;

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    done_ends_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $fell(busy));

    // R4
    rk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || rk_idx == $past(rk_idx) + 1'b1));

    // R4
    round_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (r_q.round >= RND_W'(1) && r_q.round <= LAST_RND));

    // R1
    start_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(ld_vld) && rk_idx == IDX_W'(NCOL)));

    // R6
    ct_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ct) |-> (busy || done));
endmodule

// File: tb/test_aes_ws_core.sv
module test_aes_ws_core;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ld_vld = 1'b0;
    logic [31:0]  ld_data = '0;
    logic [31:0]  ld_key = '0;
    logic [31:0]  rk_word;
    logic [5:0]   rk_idx;
    logic         busy, done;
    logic [127:0] ct;

    logic [31:0]  rk_tab [64];
    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    // Stand-in for the key-expansion block
    assign rk_word = rk_tab[rk_idx];

    aes_ws_core i_aes_ws_core (
        .clk(clk), .rst_n(rst_n), .ld_vld(ld_vld), .ld_data(ld_data),
        .ld_key(ld_key), .rk_word(rk_word), .rk_idx(rk_idx),
        .busy(busy), .done(done), .ct(ct)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] tmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r = 0, x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r ^= x;
            x = (x << 1) ^ (x[7] ? 8'h1b : 8'h00);
        end
        return r;
    endfunction

    function automatic logic [7:0] tsbox(input logic [7:0] a);
        logic [7:0] inv = 0, y;
        logic [7:0] c = 8'h63;
        for (int j = 1; j < 256; j++)
            if (tmul(a, 8'(j)) == 8'h01) inv = 8'(j);
        for (int i = 0; i < 8; i++)
            y[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ c[i];
        return y;
    endfunction

    task automatic expand(input logic [127:0] key);
        logic [7:0] rc = 8'h01;
        for (int i = 0; i < 64; i++) rk_tab[i] = '0;
        for (int i = 0; i < 4; i++) rk_tab[i] = key[127-32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            logic [31:0] t = rk_tab[i-1];
            if (i % 4 == 0) begin
                t = {t[23:0], t[31:24]};
                t = {tsbox(t[31:24]), tsbox(t[23:16]), tsbox(t[15:8]), tsbox(t[7:0])};
                t[31:24] ^= rc;
                rc = tmul(rc, 8'h02);
            end
            rk_tab[i] = rk_tab[i-4] ^ t;
        end
    endtask

    function automatic logic [127:0] ref_enc(input logic [127:0] pt);
        logic [7:0] s [16];
        logic [7:0] t [16];
        for (int i = 0; i < 16; i++) s[i] = pt[127-8*i -: 8] ^ rk_tab[i/4][31-8*(i%4) -: 8];
        for (int rnd = 1; rnd <= 10; rnd++) begin
            for (int i = 0; i < 16; i++) s[i] = tsbox(s[i]);
            for (int c = 0; c < 4; c++)
                for (int r = 0; r < 4; r++) t[4*c+r] = s[4*((c+r)%4)+r];
            for (int c = 0; c < 4; c++)
                for (int r = 0; r < 4; r++) begin
                    if (rnd < 10)
                        s[4*c+r] = tmul(t[4*c+r], 2) ^ tmul(t[4*c+(r+1)%4], 3)
                                 ^ t[4*c+(r+2)%4] ^ t[4*c+(r+3)%4];
                    else
                        s[4*c+r] = t[4*c+r];
                    s[4*c+r] ^= rk_tab[4*rnd+c][31-8*r -: 8];
                end
        end
        for (int i = 0; i < 16; i++) ref_enc[127-8*i -: 8] = s[i];
    endfunction

    task automatic run_one(input logic [127:0] pt, input logic [127:0] key,
                           input bit gaps, input bit noise, input logic [127:0] known);
        logic [127:0] exp;
        bit idx_ok = 1'b1;
        expand(key);
        exp = ref_enc(pt);
        if (known != '0) chk(exp == known, "R3 model vector", exp, known);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (gaps) begin
                ld_vld = 1'b0;
                repeat ($urandom % 3 + 1) @(negedge clk);
            end
            if (k == 3) chk(busy == 1'b0, "R1/R7 busy low after 3 words", 128'(busy), 0);
            ld_vld  = 1'b1;
            ld_data = pt[127-32*k -: 32];
            ld_key  = key[127-32*k -: 32];
        end
        @(negedge clk);
        ld_vld = 1'b0;
        chk(busy == 1'b1 && rk_idx == 6'd4, "R1 busy after 4th word", {busy, rk_idx}, {1'b1, 6'd4});
        for (int i = 1; i <= 44; i++) begin
            if (noise && i < 39) begin
                ld_vld  = $urandom % 2;
                ld_data = $urandom;
                ld_key  = $urandom;
            end else begin
                ld_vld = 1'b0;
            end
            @(negedge clk);
            if (i < 40) begin
                if (!(busy && !done && rk_idx == 6'(4 + i))) begin
                    if (idx_ok) chk(1'b0, "R4 rk_idx sequence", {busy, done, rk_idx}, {1'b1, 1'b0, 6'(4 + i)});
                    idx_ok = 1'b0;
                end
            end else if (i == 40) begin
                chk(done == 1'b1 && busy == 1'b0, "R5 done timing", {done, busy}, 2'b10);
                chk(ct == exp, noise ? "R2/R3 ciphertext with noise" : "R3 ciphertext", ct, exp);
            end else begin
                chk(done == 1'b0 && ct == exp, "R5/R6 single pulse and hold", {done, ct}, {1'b0, exp});
            end
        end
        if (idx_ok) chk(1'b1, "R4 rk_idx sequence", 0, 0);
    endtask

    initial begin
        void'($urandom(32'h5eed_a3c1));
        for (int i = 0; i < 64; i++) rk_tab[i] = '0;
        repeat (3) @(negedge clk);
        // R8 reset state
        chk(busy == 0 && done == 0 && ct == 0 && rk_idx == 0, "R8 reset", {busy, done, rk_idx, ct[63:0]}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_one(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f,
                1'b0, 1'b0, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
        run_one(128'h3243f6a8885a308d313198a2e0370734, 128'h2b7e151628aed2a6abf7158809cf4f3c,
                1'b1, 1'b1, 128'h3925841d02dc09fbdc118597196a0b32);
        // Corner cases: all zeros, all ones (exercises the 0x1B reduction)
        run_one('0, '0, 1'b0, 1'b0, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e);
        run_one({4{32'hffffffff}}, {4{32'hffffffff}}, 1'b1, 1'b0, '0);
        for (int n = 0; n < 10; n++)
            run_one({$urandom, $urandom, $urandom, $urandom},
                    {$urandom, $urandom, $urandom, $urandom},
                    1'($urandom), 1'($urandom), '0);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule